// File: doc/BRIEF.md
# SPI FIFO event and interrupt status unit

This unit sits beside the transmit and receive FIFOs of a SPI controller and turns their occupancy into software-visible status. It takes the live receive and transmit level counts and compares each with a programmable watermark. The receive watermark and the transmit watermark are held in a mode register. A receive-has-data event and a transmit-has-room event are latched as sticky flags. Software clears each flag by writing a one to its bit.

An event register shows the two live level counts next to the two sticky flags. A mask register with the same bit layout selects which flags may raise the single level interrupt. The interrupt is a registered output. Software reads and writes all three registers through a simple select/write port. Reads are combinational from the select input.

Top module: `spi_evt_status`

## Requirements
- R1: At reset both event flags and both mask bits are 0, the interrupt is low, and the mode register reads 0x00000403: transmit watermark 4 in bits 13:8 and receive watermark 3 in bits 5:0.
- R2: With read select 1, the event register shows the live receive level in bits 29:24 and the live transmit level in bits 21:16, in the same cycle. Writes to these fields have no effect.
- R3: The receive flag (event bit 9) becomes 1 on the clock edge at which the receive level is greater than the receive watermark. After that it stays 1 until it is cleared.
- R4: The transmit flag (event bit 8) becomes 1 on the clock edge at which the transmit level is less than the transmit watermark. After that it stays 1 until it is cleared.
- R5: A write to the event register (select 1) clears each flag whose data bit is 1, from the next cycle on. A 0 in a data bit leaves that flag as it is. If a flag's set condition holds in the same cycle as its clear, the flag stays 1.
- R6: A write to the mask register (select 2) stores data bits 9 and 8 as the mask for the receive flag and the transmit flag. On read, every other bit of the mask register is 0.
- R7: The interrupt output is high in the cycle after any flag and its mask bit were both 1 at a clock edge. Otherwise it is low.
- R8: A write to the mode register (select 0) loads both watermarks from bits 13:8 and 5:0, and all other bits read 0. The new watermarks take part in the comparisons from the next edge on. Select 3 reads as 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | LVL_W | Live receive FIFO occupancy |
| tx_level | input | LVL_W | Live transmit FIFO occupancy |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write target: 0 mode, 1 event, 2 mask |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Read target, same encoding |
| reg_rdata | output | 32 | Read data for reg_rsel |
| irq_o | output | 1 | Level interrupt |

## Verification
The level count fields and all read data follow their inputs with no delay. They are compared half a clock after the inputs change. A flag responds to a level condition or a write one edge after the stimulus, and the interrupt follows one edge later, so it lags a level change by two edges. The bench's reference model advances on the same edge as the design and is sampled on the falling edge. Every expected value therefore carries exactly these latencies, and no check depends on the order in which processes run at an edge.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
   localparam int REG_W      = 32;
   localparam int FLD_W      = 6;
   localparam int RXCNT_LSB  = 24;
   localparam int TXCNT_LSB  = 16;
   localparam int FLAG_LSB   = 8;   // bit 8 tx room, bit 9 rx data
   localparam int NFLAG      = 2;
   localparam int TXTHR_LSB  = 8;
   localparam int RXTHR_LSB  = 0;

   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_EVT  = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/spi_evt_thresh.sv
module spi_evt_thresh #(
   parameter int LVL_W  = 6,
   parameter int RX_RST = 3,
   parameter int TX_RST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LVL_W-1:0] rx_thr_d,
   input  logic [LVL_W-1:0] tx_thr_d,
   output logic [LVL_W-1:0] rx_thr_q,
   output logic [LVL_W-1:0] tx_thr_q
);
   localparam logic [LVL_W-1:0] RX_INIT = LVL_W'(RX_RST);
   localparam logic [LVL_W-1:0] TX_INIT = LVL_W'(TX_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_thr_q <= RX_INIT;
         tx_thr_q <= TX_INIT;
      end else if (load_i) begin
         rx_thr_q <= rx_thr_d;
         tx_thr_q <= tx_thr_d;
      end
   end
endmodule

// File: rtl/spi_evt_flag.sv
module spi_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= set_i | (flag_o & ~clr_i);
   end
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(evt_i & mask_i);
   end
endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status
   import spi_evt_pkg::*;
#(
   parameter int LVL_W  = 6,
   parameter int RX_RST = 3,
   parameter int TX_RST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             reg_we,
   input  logic [1:0]       reg_wsel,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic [1:0]       reg_rsel,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_o
);
   generate
      if (LVL_W < 1 || LVL_W > FLD_W) begin : g_bad_width
         $error("LVL_W must be between 1 and 6");
      end
      if (RX_RST >= (1 << LVL_W) || TX_RST >= (1 << LVL_W)) begin : g_bad_rst
         $error("watermark reset value does not fit LVL_W");
      end
   endgenerate

   logic             mode_wr, evt_wr, mask_wr;
   logic [LVL_W-1:0] rx_thr, tx_thr;
   logic [NFLAG-1:0] cond, clr, flags;
   logic [NFLAG-1:0] mask_q;

   assign mode_wr = reg_we && (reg_wsel == SEL_MODE);
   assign evt_wr  = reg_we && (reg_wsel == SEL_EVT);
   assign mask_wr = reg_we && (reg_wsel == SEL_MASK);

   spi_evt_thresh #(.LVL_W(LVL_W), .RX_RST(RX_RST), .TX_RST(TX_RST)) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (mode_wr),
      .rx_thr_d (reg_wdata[RXTHR_LSB +: LVL_W]),
      .tx_thr_d (reg_wdata[TXTHR_LSB +: LVL_W]),
      .rx_thr_q (rx_thr),
      .tx_thr_q (tx_thr)
   );

   // index 0: transmit has room, index 1: receive has data
   assign cond[0] = (tx_level < tx_thr);
   assign cond[1] = (rx_level > rx_thr);

   generate
      for (genvar g = 0; g < NFLAG; g++) begin : g_flag
         assign clr[g] = evt_wr & reg_wdata[FLAG_LSB + g];
         spi_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (cond[g]),
            .clr_i  (clr[g]),
            .flag_o (flags[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= reg_wdata[FLAG_LSB +: NFLAG];
   end

   spi_evt_irq #(.N(NFLAG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (flags),
      .mask_i (mask_q),
      .irq_o  (irq_o)
   );

   logic [FLD_W-1:0] rx_fld, tx_fld, rxt_fld, txt_fld;
   always_comb begin
      rx_fld  = '0;
      tx_fld  = '0;
      rxt_fld = '0;
      txt_fld = '0;
      rx_fld[LVL_W-1:0]  = rx_level;
      tx_fld[LVL_W-1:0]  = tx_level;
      rxt_fld[LVL_W-1:0] = rx_thr;
      txt_fld[LVL_W-1:0] = tx_thr;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_rsel)
         SEL_MODE: begin
            reg_rdata[RXTHR_LSB +: FLD_W] = rxt_fld;
            reg_rdata[TXTHR_LSB +: FLD_W] = txt_fld;
         end
         SEL_EVT: begin
            reg_rdata[RXCNT_LSB +: FLD_W] = rx_fld;
            reg_rdata[TXCNT_LSB +: FLD_W] = tx_fld;
            reg_rdata[FLAG_LSB +: NFLAG]  = flags;
         end
         SEL_MASK: reg_rdata[FLAG_LSB +: NFLAG] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_evt_chk.sv
module spi_evt_chk #(
   parameter int LVL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level,
   input logic [LVL_W-1:0] tx_level,
   input logic [LVL_W-1:0] rx_thr,
   input logic [LVL_W-1:0] tx_thr,
   input logic             reg_we,
   input logic [1:0]       reg_wsel,
   input logic [31:0]      reg_wdata,
   input logic [1:0]       flags,
   input logic [1:0]       mask_q,
   input logic             irq_o
);
   assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level > rx_thr) |=> flags[1]);

   assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level < tx_thr) |=> flags[0]);

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wsel == 2'd1 && reg_wdata[9] && !(rx_level > rx_thr)) |=> !flags[1]);

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(reg_we && reg_wsel == 2'd1)) |=> flags[0]);

   assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wsel == 2'd2) |=> (mask_q == $past(reg_wdata[9:8])));

   assert_irq_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & mask_q)) |=> irq_o);

   assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags & mask_q)) |=> !irq_o);

   assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wsel == 2'd0) |=> (rx_thr == $past(reg_wdata[LVL_W-1:0])));
endmodule

bind spi_evt_status spi_evt_chk #(.LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_level  (rx_level),
   .tx_level  (tx_level),
   .rx_thr    (rx_thr),
   .tx_thr    (tx_thr),
   .reg_we    (reg_we),
   .reg_wsel  (reg_wsel),
   .reg_wdata (reg_wdata),
   .flags     (flags),
   .mask_q    (mask_q),
   .irq_o     (irq_o)
);

// File: tb/spi_evt_status_tb.sv
module spi_evt_status_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  rx_level = '0, tx_level = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_wsel = '0, reg_rsel = 2'd1;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   spi_evt_status u_dut (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
      .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
      .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   // behavioural reference model
   int m_rxthr, m_txthr;
   bit m_rxf, m_txf, m_mrx, m_mtx, m_irq;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rxthr <= 3; m_txthr <= 4;
         m_rxf <= 0; m_txf <= 0; m_mrx <= 0; m_mtx <= 0; m_irq <= 0;
      end else begin
         m_irq <= (m_rxf && m_mrx) || (m_txf && m_mtx);
         m_rxf <= (int'(rx_level) > m_rxthr) ||
                  (m_rxf && !(reg_we && reg_wsel == 1 && reg_wdata[9]));
         m_txf <= (int'(tx_level) < m_txthr) ||
                  (m_txf && !(reg_we && reg_wsel == 1 && reg_wdata[8]));
         if (reg_we && reg_wsel == 0) begin
            m_rxthr <= int'(reg_wdata[5:0]);
            m_txthr <= int'(reg_wdata[13:8]);
         end
         if (reg_we && reg_wsel == 2) begin
            m_mrx <= reg_wdata[9];
            m_mtx <= reg_wdata[8];
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // comparison on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R7 irq", int'(irq_o), int'(m_irq));
         case (reg_rsel)
            2'd0: begin
               check("R8 rx watermark", int'(reg_rdata[5:0]), m_rxthr);
               check("R8 tx watermark", int'(reg_rdata[13:8]), m_txthr);
               check("R8 mode spare bits", int'(reg_rdata & 32'hFFFF_C0C0), 0);
            end
            2'd1: begin
               check("R2 rx level field", int'(reg_rdata[29:24]), int'(rx_level));
               check("R2 tx level field", int'(reg_rdata[21:16]), int'(tx_level));
               check("R3 rx flag", int'(reg_rdata[9]), int'(m_rxf));
               check("R4 tx flag", int'(reg_rdata[8]), int'(m_txf));
               check("R5 event spare bits", int'(reg_rdata & 32'hC0C0_FCFF), 0);
            end
            2'd2: begin
               check("R6 mask bits", int'(reg_rdata[9:8]), int'({m_mrx, m_mtx}));
               check("R6 mask spare bits", int'(reg_rdata & 32'hFFFF_FCFF), 0);
            end
            default: check("R8 unused select", int'(reg_rdata), 0);
         endcase
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
      tick(1);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tx_level = 6'd10;   // no room condition so flags stay low
      tick(3);
      // R1 reset values, sampled while reset is held
      @(negedge clk);
      check("R1 irq low", int'(irq_o), 0);
      check("R1 flags clear", int'(reg_rdata[9:8]), 0);
      reg_rsel = 2'd0; #1;
      check("R1 mode default", int'(reg_rdata), 32'h0000_0403);
      reg_rsel = 2'd2; #1;
      check("R1 mask clear", int'(reg_rdata), 0);
      reg_rsel = 2'd1;
      @(posedge clk); #1;
      rst_n = 1'b1;
      tick(2);
      // R2 live counts, several patterns; writes to count fields ignored
      rx_level = 6'd2; tx_level = 6'd33; tick(1);
      rx_level = 6'd0; tx_level = 6'd63; tick(1);
      wr(2'd1, 32'h3F3F_0000);
      tick(1);
      // R3 rx flag: level equal to watermark does not set, above does
      rx_level = 6'd3; tick(2);
      rx_level = 6'd4; tick(1);
      rx_level = 6'd0; tick(2);
      // R5 clear while condition absent
      wr(2'd1, 32'h0000_0200); tick(2);
      // R5 set wins over clear
      rx_level = 6'd9; tick(1);
      wr(2'd1, 32'h0000_0300); tick(1);
      rx_level = 6'd1; tick(1);
      wr(2'd1, 32'h0000_0100); tick(1);   // clearing bit 8 only leaves bit 9
      wr(2'd1, 32'hFFFF_FFFF); tick(2);
      // R6 and R7 mask and interrupt
      reg_rsel = 2'd2;
      wr(2'd2, 32'hFFFF_FFFF); tick(1);
      wr(2'd2, 32'h0000_0200); tick(1);
      reg_rsel = 2'd1;
      rx_level = 6'd5; tick(4);
      rx_level = 6'd0; wr(2'd1, 32'h0000_0200); tick(3);
      // R4 tx flag, masked off then unmasked
      tx_level = 6'd4; tick(2);
      tx_level = 6'd3; tick(1);
      tx_level = 6'd20; tick(1);
      wr(2'd2, 32'h0000_0100); tick(3);
      wr(2'd1, 32'h0000_0100); tick(3);
      // R8 new watermarks
      reg_rsel = 2'd0;
      wr(2'd0, 32'hFFFF_2A15); tick(1);
      reg_rsel = 2'd1;
      rx_level = 6'd21; tx_level = 6'd42; tick(2);
      rx_level = 6'd22; tx_level = 6'd41; tick(2);
      wr(2'd1, 32'h0000_0300); tick(1);
      // R8 select 3: reads zero, writes have no effect
      reg_rsel = 2'd3;
      wr(2'd3, 32'hFFFF_FFFF); tick(1);
      reg_rsel = 2'd0; tick(1);
      reg_rsel = 2'd2; tick(1);
      reg_rsel = 2'd1; rx_level = 6'd0; tx_level = 6'd60;
      wr(2'd1, 32'hFFFF_FFFF); tick(3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule